// File: doc/BRIEF.md
# Not-Recently-Used Replacement Selector

This block holds the replacement state of an N-way set-associative cache and chooses eviction victims under a not-recently-used policy. Every way of every set carries one candidate flag. A flag at one marks the way as evictable, and a flag at zero marks a way that has been used recently. Each time the cache reports a hit or a fill through the touch port, the flag of that way is cleared. When a touch would leave a set with no candidate at all, the whole set is re-armed in the same update.

The victim port is combinational. The cache presents a set index with a request strobe. In the same cycle the block returns the lowest-numbered way whose flag is one, together with a valid flag. A victim query and a touch in the same cycle see the state as it was before that touch. Tag compare, data storage and miss handling belong to the surrounding cache.

Top module: `nru_sel`

## Requirements
- R1: A synchronous reset, active high, sets every flag of every set to one, so a query to any set after reset returns way 0.
- R2: A touch with `touch_vld` high clears the flag of way `touch_way` in set `touch_set` at the next clock edge, provided other flags of that set remain one.
- R3: The returned victim is always the lowest-numbered way whose flag is one in the queried set.
- R4: A touch that would leave every flag of its set at zero sets all flags of that set to one at the same edge, so the next query to that set returns way 0. No set is ever without a candidate.
- R5: A touch changes only the set it names. Queries to other sets are unaffected.
- R6: A query in the same cycle as a touch to the same set returns a victim based on the state before that touch.
- R7: `victim_vld` is high exactly when `vq_req` is high.
- R8: With `touch_vld` low, the values on `touch_set` and `touch_way` have no effect on any flag.
- R9: Touching a way whose flag is already zero changes no flag, unless it triggers the re-arm of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| touch_vld | input | 1 | Touch strobe |
| touch_set | input | $clog2(SETS) | Set being touched |
| touch_way | input | $clog2(WAYS) | Way being touched |
| vq_req | input | 1 | Victim query strobe |
| vq_set | input | $clog2(SETS) | Set being queried |
| victim_way | output | $clog2(WAYS) | Chosen way to evict |
| victim_vld | output | 1 | Victim output valid |

## Verification
The bench clears the ways of one set in a scattered order. A selector with the wrong priority would report a higher way, and one missing the re-arm would return a way whose flag is zero, or stall on an empty set. Same-cycle query and touch are checked against the pre-touch victim; a design that bypassed the touch would already skip the way being touched. Repeat touches, masked touches and touches to a neighbouring set are each followed by queries, so an update that leaked would show up as a shifted victim.

// File: rtl/nru_sel.sv
module nru_sel #(
  parameter int WAYS = 8,
  parameter int SETS = 64,
  localparam int WB = $clog2(WAYS),
  localparam int SB = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_vld,
  input  logic [SB-1:0] touch_set,
  input  logic [WB-1:0] touch_way,
  input  logic          vq_req,
  input  logic [SB-1:0] vq_set,
  output logic [WB-1:0] victim_way,
  output logic          victim_vld
);

  logic [WAYS-1:0] cand [SETS];
  logic [WAYS-1:0] rd_row, tc_row, tc_clr, tc_next;
  logic [WB-1:0]   pick;

  assign rd_row  = cand[vq_set];
  assign tc_row  = cand[touch_set];
  assign tc_clr  = tc_row & ~(WAYS'(1) << touch_way);
  assign tc_next = (tc_clr == '0) ? '1 : tc_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) cand[s] <= '1;
    end else if (touch_vld) begin
      cand[touch_set] <= tc_next;
    end
  end

  always_comb begin
    pick = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (rd_row[i]) pick = WB'(i);
  end

  assign victim_way = pick;
  assign victim_vld = vq_req & (|rd_row);

endmodule

// File: rtl/nru_sel_chk.sv
module nru_sel_chk #(
  parameter int WAYS = 8,
  parameter int SETS = 64,
  localparam int WB = $clog2(WAYS),
  localparam int SB = $clog2(SETS)
) (
  input logic          clk,
  input logic          rst,
  input logic          touch_vld,
  input logic [SB-1:0] touch_set,
  input logic [WB-1:0] touch_way,
  input logic          vq_req,
  input logic [SB-1:0] vq_set,
  input logic [WB-1:0] victim_way,
  input logic          victim_vld,
  input logic [WAYS-1:0] rd_row,
  input logic [WAYS-1:0] tc_row
);

  logic [WAYS-1:0] below, left;
  always_comb begin
    below = '0;
    for (int i = 0; i < WAYS; i++) below[i] = (i < int'(victim_way));
  end
  assign left = tc_row & ~(WAYS'(1) << touch_way);

  AST_RESET_ARMED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_row == '1);  // R1
  AST_TOUCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (touch_vld && left != '0) |=> (vq_set == $past(touch_set) |-> !rd_row[$past(touch_way)]));  // R2
  AST_LOWEST_ARMED: assert property (@(posedge clk) disable iff (rst)
    victim_vld |-> (rd_row[victim_way] && (rd_row & below) == '0));  // R3
  AST_NEVER_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rd_row != '0);  // R4
  AST_REARM: assert property (@(posedge clk) disable iff (rst)
    (touch_vld && left == '0) |=> (vq_set == $past(touch_set) |-> rd_row == '1));  // R4
  AST_VLD_REQ: assert property (@(posedge clk) disable iff (rst)
    victim_vld == vq_req);  // R7

endmodule

bind nru_sel nru_sel_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk(clk), .rst(rst), .touch_vld(touch_vld), .touch_set(touch_set),
  .touch_way(touch_way), .vq_req(vq_req), .vq_set(vq_set),
  .victim_way(victim_way), .victim_vld(victim_vld),
  .rd_row(rd_row), .tc_row(tc_row)
);

// File: tb/tb_nru_sel.sv
module tb_nru_sel;
  localparam int WAYS = 4;
  localparam int SETS = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       touch_vld = 1'b0;
  logic [2:0] touch_set = '0;
  logic [1:0] touch_way = '0;
  logic       vq_req = 1'b0;
  logic [2:0] vq_set = '0;
  logic [1:0] victim_way;
  logic       victim_vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  nru_sel #(.WAYS(WAYS), .SETS(SETS)) dut (
    .clk(clk), .rst(rst), .touch_vld(touch_vld), .touch_set(touch_set),
    .touch_way(touch_way), .vq_req(vq_req), .vq_set(vq_set),
    .victim_way(victim_way), .victim_vld(victim_vld)
  );

  // {touch_vld, touch_set, touch_way, vq_req, vq_set, exp_vld, exp_way, req}
  localparam int NV = 16;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 3'd2, 2'd0, 1'b1, 3'd2, 1'b1, 2'd0, 4'd6},  // R6 pre-touch view
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd2, 1'b1, 2'd1, 4'd2},  // R2 way0 cleared
    {1'b1, 3'd2, 2'd2, 1'b1, 3'd2, 1'b1, 2'd1, 4'd3},
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd2, 1'b1, 2'd1, 4'd3},  // R3 lowest of 1,3
    {1'b1, 3'd2, 2'd1, 1'b1, 3'd2, 1'b1, 2'd1, 4'd6},
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd2, 1'b1, 2'd3, 4'd3},  // R3 only way3 left
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd5, 1'b1, 2'd0, 4'd5},  // R5 other set intact
    {1'b1, 3'd2, 2'd3, 1'b1, 3'd2, 1'b1, 2'd3, 4'd6},  // last candidate touched
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd2, 1'b1, 2'd0, 4'd4},  // R4 re-armed
    {1'b1, 3'd5, 2'd0, 1'b1, 3'd5, 1'b1, 2'd0, 4'd6},
    {1'b1, 3'd5, 2'd0, 1'b1, 3'd5, 1'b1, 2'd1, 4'd9},  // R9 repeat touch
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd5, 1'b1, 2'd1, 4'd9},
    {1'b0, 3'd5, 2'd1, 1'b1, 3'd5, 1'b1, 2'd1, 4'd8},  // R8 masked touch
    {1'b0, 3'd5, 2'd1, 1'b1, 3'd5, 1'b1, 2'd1, 4'd8},
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd2, 1'b1, 2'd0, 4'd5},  // R5 set2 unaffected by set5
    {1'b0, 3'd0, 2'd0, 1'b0, 3'd5, 1'b0, 2'd0, 4'd7}   // R7 no request
  };

  task automatic check(input logic ev, input logic [1:0] ew, input int rq);
    checks++;
    if (victim_vld !== ev || (ev && victim_way !== ew)) begin
      fails++;
      $display("FAIL R%0d: vld=%0b way=%0d expected vld=%0b way=%0d",
               rq, victim_vld, victim_way, ev, ew);
    end
  endtask

  task automatic apply(input logic tv, input logic [2:0] ts, input logic [1:0] tw,
                       input logic qr, input logic [2:0] qs);
    @(negedge clk);
    touch_vld = tv; touch_set = ts; touch_way = tw; vq_req = qr; vq_set = qs;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: all sets start fully armed
    for (int s = 0; s < SETS; s++) begin
      apply(1'b0, 3'd0, 2'd0, 1'b1, 3'(s));
      check(1'b1, 2'd0, 1);
    end
    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][16], VEC[k][15:13], VEC[k][12:11], VEC[k][10], VEC[k][9:7]);
      check(VEC[k][6], VEC[k][5:4], int'(VEC[k][3:0]));
    end
    // R1: reset mid-run re-arms set 5 (way0 had been cleared)
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    apply(1'b0, 3'd0, 2'd0, 1'b1, 3'd5);
    check(1'b1, 2'd0, 1);
    // R4: clear all four ways of set 7 in reverse order, then re-arm
    for (int w = 3; w >= 0; w--) apply(1'b1, 3'd7, 2'(w), 1'b0, 3'd7);
    apply(1'b0, 3'd0, 2'd0, 1'b1, 3'd7);
    check(1'b1, 2'd0, 4);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule